// File: doc/BRIEF.md
# FIFO Reset and Offset Programming Controller

This block sits beside a FIFO's storage and pointer logic and decides when that logic is reset and how its almost-empty and almost-full thresholds are set. It accepts two reset inputs that may change at any time relative to the clock. A full reset reconfigures everything. A partial reset clears only the pointers and flags. Each input passes through a two-flop synchronizer. It counts as a reset only when it stays low for a minimum number of clock edges, so short glitches are ignored.

When a full reset is released, the block samples the mode pins. These pins choose how the two offsets are filled: from a built-in preset, by two parallel writes, or by a serial bit stream. The same release latches the byte-order bit. The clock edge after that latches the timing-mode bit, taken from the same shared pin. A partial reset leaves the offsets, the programming method and both mode bits untouched. Both kinds of reset hold the flag-initialise and mailbox-force outputs high and end with a single pointer-clear pulse.

Top module: `fifo_rst_ctrl`

## Requirements
- R1: A reset input counts as a reset only when it stays low for at least MIN_LOW (default 4) rising clock edges after the two-flop synchronizer. A shorter low pulse has no effect: no pointer-clear pulse and no flag or mailbox forcing.
- R2: While a qualified reset is held low, `flags_init` and `mbox_force` are both high.
- R3: Releasing a qualified reset makes `ptr_clear` high for exactly one cycle. It becomes visible after the third rising edge following the release.
- R4: On release of a full reset, `big_endian` takes the value of `order_sel` at the releasing edge. `fall_through` takes the inverse of `order_sel` at the next edge. The value 1 means big-endian, and the value 0 selects fall-through timing.
- R5: The mode is decoded at full-reset release. If `spm_sel`=0, the mode is serial (`prog_mode`=3). If `spm_sel`=1 and `fs_sel`=00, the mode is parallel (`prog_mode`=2). If `spm_sel`=1 and `fs_sel` is non-zero, the mode is preset (`prog_mode`=1).
- R6: Preset values are loaded into both offsets, and `ofs_ready` is raised at release. `fs_sel`=11 gives 64, `fs_sel`=10 gives 16, and `fs_sel`=01 gives 8.
- R7: In parallel mode, the first `prog_wr` loads `ofs_ae` from `wr_data`. The second loads `ofs_af` and raises `ofs_ready`. Later writes are ignored.
- R8: In serial mode, each cycle with `ser_en` high shifts in one `ser_data` bit. The almost-empty offset comes first, then the almost-full offset, each most significant bit first. `ofs_ready` rises after 2*OFS_W bits, and further bits are ignored.
- R9: A partial reset leaves `ofs_ae`, `ofs_af`, `ofs_ready`, `prog_mode`, `big_endian` and `fall_through` unchanged.
- R10: A full reset into parallel or serial mode clears both offsets to 0 and drops `ofs_ready`.
- R11: `prog_wr` has no effect outside parallel mode, and `ser_en` has no effect outside serial mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| full_rst_n | input | 1 | Full reset request, active low, asynchronous |
| part_rst_n | input | 1 | Partial reset request, active low, asynchronous |
| order_sel | input | 1 | Shared byte-order / timing-mode select pin |
| spm_sel | input | 1 | Programming-method select, sampled at full release |
| fs_sel | input | 2 | Preset select, sampled at full release |
| wr_data | input | OFS_W | Write-port data lanes carrying parallel offsets |
| prog_wr | input | 1 | Parallel offset write strobe |
| ser_data | input | 1 | Serial offset bit |
| ser_en | input | 1 | Serial bit qualifier |
| ofs_ae | output | OFS_W | Almost-empty offset |
| ofs_af | output | OFS_W | Almost-full offset |
| ofs_ready | output | 1 | Both offsets are loaded |
| prog_mode | output | 2 | Latched programming method |
| big_endian | output | 1 | Latched byte order |
| fall_through | output | 1 | Latched timing mode |
| ptr_clear | output | 1 | One-cycle pointer-clear strobe |
| flags_init | output | 1 | Hold FIFO flags in their reset state |
| mbox_force | output | 1 | Force the mailbox flags high |

## Verification
The assertions assume that two reset releases never land on consecutive cycles. They also assume that `order_sel`, `spm_sel` and `fs_sel` are steady around the full-reset release edge. The bench keeps to this by running one reset at a time. It holds each reset low for at least six cycles, or for exactly the qualifying or non-qualifying count in the glitch test. It changes `order_sel` only in the cycle after the pointer-clear pulse, which is the cycle the timing-mode bit is defined to use. All stimulus is driven on the falling edge.

// File: rtl/fifo_rst_pkg.sv
package fifo_rst_pkg;

  typedef enum logic [1:0] {
    PM_NONE     = 2'd0,
    PM_PRESET   = 2'd1,
    PM_PARALLEL = 2'd2,
    PM_SERIAL   = 2'd3
  } prog_mode_e;

  // Method chosen from the mode pins sampled at full-reset release.
  function automatic prog_mode_e decode_mode(input logic spm, input logic [1:0] fs);
    if (!spm)            return PM_SERIAL;
    else if (fs == 2'b00) return PM_PARALLEL;
    else                 return PM_PRESET;
  endfunction

  // Preset threshold for a non-zero select code.
  function automatic int unsigned preset_offset(input logic [1:0] fs);
    case (fs)
      2'b11:   return 64;
      2'b10:   return 16;
      2'b01:   return 8;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/rst_qualifier.sv
module rst_qualifier #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 4
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic armed,
  output logic release_pulse
);
  localparam int CNT_W = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_LOW);

  logic [SYNC_STAGES-1:0] sync_q = '1;
  logic [CNT_W-1:0]       low_cnt_q = '0;
  logic                   lvl;

  always_ff @(posedge clk) begin
    sync_q <= {sync_q[SYNC_STAGES-2:0], rst_n_async};
  end
  assign lvl = sync_q[SYNC_STAGES-1];

  // Count synchronized low cycles, saturating at the qualification limit.
  always_ff @(posedge clk) begin
    if (lvl)                  low_cnt_q <= '0;
    else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign armed         = (low_cnt_q == CNT_MAX);
  assign release_pulse = armed && lvl;

  AST_RELEASE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n_async)
    release_pulse |-> $past(!lvl)) else $error("release without held low"); // R1

  AST_COUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_async)
    release_pulse |=> !armed) else $error("qualifier stays armed"); // R3
endmodule

// File: rtl/offset_loader.sv
module offset_loader
  import fifo_rst_pkg::*;
#(
  parameter int OFS_W = 10
) (
  input  logic             clk,
  input  logic             full_rel,
  input  logic             hold,
  input  logic             spm_in,
  input  logic [1:0]       fs_in,
  input  logic [OFS_W-1:0] wr_data,
  input  logic             prog_wr,
  input  logic             ser_data,
  input  logic             ser_en,
  output logic [OFS_W-1:0] ofs_ae,
  output logic [OFS_W-1:0] ofs_af,
  output logic             ready,
  output prog_mode_e       mode
);
  localparam int TOTAL_BITS = 2 * OFS_W;
  localparam int BC_W       = $clog2(TOTAL_BITS + 1);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(TOTAL_BITS - 1);

  logic [OFS_W-1:0] ae_q = '0, af_q = '0;
  logic             ready_q = 1'b0;
  logic             par_second_q = 1'b0;
  logic [BC_W-1:0]  bit_cnt_q = '0;
  prog_mode_e       mode_q = PM_NONE;

  // Named events for the assertions.
  logic par_take, ser_take, is_preset;
  logic [OFS_W-1:0] preset_val;

  assign par_take   = !hold && (mode_q == PM_PARALLEL) && !ready_q && prog_wr;
  assign ser_take   = !hold && (mode_q == PM_SERIAL)   && !ready_q && ser_en;
  assign is_preset  = (decode_mode(spm_in, fs_in) == PM_PRESET);
  assign preset_val = OFS_W'(preset_offset(fs_in));

  always_ff @(posedge clk) begin
    if (full_rel) begin
      mode_q       <= decode_mode(spm_in, fs_in);
      ae_q         <= is_preset ? preset_val : '0;
      af_q         <= is_preset ? preset_val : '0;
      ready_q      <= is_preset;
      par_second_q <= 1'b0;
      bit_cnt_q    <= '0;
    end else begin
      if (par_take) begin
        if (!par_second_q) begin
          ae_q         <= wr_data;
          par_second_q <= 1'b1;
        end else begin
          af_q    <= wr_data;
          ready_q <= 1'b1;
        end
      end
      if (ser_take) begin
        {ae_q, af_q} <= {ae_q[OFS_W-2:0], af_q, ser_data};
        bit_cnt_q    <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == LAST_BIT) ready_q <= 1'b1;
      end
    end
  end

  assign ofs_ae = ae_q;
  assign ofs_af = af_q;
  assign ready  = ready_q;
  assign mode   = mode_q;

  AST_SER_BITS_BOUNDED: assert property (@(posedge clk) disable iff (hold)
    bit_cnt_q <= BC_W'(TOTAL_BITS)) else $error("serial count overrun"); // R8

  AST_SER_LSB_ENTRY: assert property (@(posedge clk) disable iff (hold)
    ser_take |=> af_q[0] == $past(ser_data)) else $error("serial bit lost"); // R8

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (hold)
    ready_q |=> ready_q) else $error("ready dropped without full reset"); // R9

  AST_PAR_IDLE_OUTSIDE: assert property (@(posedge clk) disable iff (hold)
    mode_q != PM_PARALLEL |-> !par_second_q) else $error("parallel state outside mode"); // R11
endmodule

// File: rtl/fifo_rst_ctrl.sv
module fifo_rst_ctrl
  import fifo_rst_pkg::*;
#(
  parameter int OFS_W       = 10,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 4
) (
  input  logic             clk,
  input  logic             full_rst_n,
  input  logic             part_rst_n,
  input  logic             order_sel,
  input  logic             spm_sel,
  input  logic [1:0]       fs_sel,
  input  logic [OFS_W-1:0] wr_data,
  input  logic             prog_wr,
  input  logic             ser_data,
  input  logic             ser_en,
  output logic [OFS_W-1:0] ofs_ae,
  output logic [OFS_W-1:0] ofs_af,
  output logic             ofs_ready,
  output logic [1:0]       prog_mode,
  output logic             big_endian,
  output logic             fall_through,
  output logic             ptr_clear,
  output logic             flags_init,
  output logic             mbox_force
);
  localparam int NUM_RST = 2;
  localparam int IDX_FULL = 0;
  localparam int IDX_PART = 1;

  logic [NUM_RST-1:0] rst_in, armed, rel;
  assign rst_in = {part_rst_n, full_rst_n};

  for (genvar g = 0; g < NUM_RST; g++) begin : g_qual
    rst_qualifier #(
      .SYNC_STAGES(SYNC_STAGES),
      .MIN_LOW    (MIN_LOW)
    ) u_qual (
      .clk          (clk),
      .rst_n_async  (rst_in[g]),
      .armed        (armed[g]),
      .release_pulse(rel[g])
    );
  end

  logic full_rel, part_rel, any_armed;
  assign full_rel  = rel[IDX_FULL];
  assign part_rel  = rel[IDX_PART];
  assign any_armed = |armed;

  // Pointer-clear strobe: one cycle after any qualified release.
  logic clr_q = 1'b0;
  always_ff @(posedge clk) clr_q <= |rel;

  // Shared pin: byte order at release, timing mode one edge later.
  logic be_q = 1'b0, ft_q = 1'b0, mode_pend_q = 1'b0;
  always_ff @(posedge clk) begin
    mode_pend_q <= full_rel;
    if (full_rel)    be_q <= order_sel;
    if (mode_pend_q) ft_q <= !order_sel;
  end

  prog_mode_e mode_w;

  offset_loader #(.OFS_W(OFS_W)) u_loader (
    .clk     (clk),
    .full_rel(full_rel),
    .hold    (any_armed),
    .spm_in  (spm_sel),
    .fs_in   (fs_sel),
    .wr_data (wr_data),
    .prog_wr (prog_wr),
    .ser_data(ser_data),
    .ser_en  (ser_en),
    .ofs_ae  (ofs_ae),
    .ofs_af  (ofs_af),
    .ready   (ofs_ready),
    .mode    (mode_w)
  );

  assign prog_mode    = mode_w;
  assign big_endian   = be_q;
  assign fall_through = ft_q;
  assign ptr_clear    = clr_q;
  assign flags_init   = any_armed || clr_q;
  assign mbox_force   = any_armed;

  AST_PTR_CLEAR_SINGLE: assert property (@(posedge clk) disable iff (armed[IDX_FULL])
    ptr_clear |=> !ptr_clear) else $error("pointer clear longer than one cycle"); // R3

  AST_PARTIAL_KEEPS: assert property (@(posedge clk) disable iff (armed[IDX_FULL])
    part_rel |=> $stable(ofs_ae) && $stable(ofs_af) && $stable(prog_mode) && $stable(ofs_ready))
    else $error("partial reset disturbed settings"); // R9

  AST_ORDER_HELD: assert property (@(posedge clk) disable iff (armed[IDX_FULL])
    mode_pend_q |=> $stable(big_endian)) else $error("byte order moved after release"); // R4

  AST_CLEAR_AFTER_HOLD: assert property (@(posedge clk) disable iff (armed[IDX_FULL])
    $rose(ptr_clear) |-> $past(mbox_force)) else $error("clear without held reset"); // R2
endmodule

// File: tb/fifo_rst_ctrl_bench.sv
module fifo_rst_ctrl_bench;
  localparam int W = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         full_rst_n = 1'b0, part_rst_n = 1'b1;
  logic         order_sel = 1'b0, spm_sel = 1'b1;
  logic [1:0]   fs_sel = 2'b11;
  logic [W-1:0] wr_data = '0;
  logic         prog_wr = 1'b0, ser_data = 1'b0, ser_en = 1'b0;
  logic [W-1:0] ofs_ae, ofs_af;
  logic         ofs_ready, big_endian, fall_through, ptr_clear, flags_init, mbox_force;
  logic [1:0]   prog_mode;

  int checks = 0, fails = 0;
  bit finished = 0;

  fifo_rst_ctrl u_fifo_rst_ctrl (
    .clk(clk), .full_rst_n(full_rst_n), .part_rst_n(part_rst_n), .order_sel(order_sel),
    .spm_sel(spm_sel), .fs_sel(fs_sel), .wr_data(wr_data), .prog_wr(prog_wr),
    .ser_data(ser_data), .ser_en(ser_en), .ofs_ae(ofs_ae), .ofs_af(ofs_af),
    .ofs_ready(ofs_ready), .prog_mode(prog_mode), .big_endian(big_endian),
    .fall_through(fall_through), .ptr_clear(ptr_clear), .flags_init(flags_init),
    .mbox_force(mbox_force)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Full reset with mode pins; order pin changes right after the clear pulse.
  task automatic full_reset(input logic spm, input logic [1:0] fs,
                            input logic ord_rst, input logic ord_after);
    spm_sel = spm; fs_sel = fs; order_sel = ord_rst;
    full_rst_n = 1'b0;
    step(8);
    chk("R2 flags_init held", flags_init, 1);
    chk("R2 mbox_force held", mbox_force, 1);
    full_rst_n = 1'b1;
    step(2);
    chk("R3 no early clear", ptr_clear, 0);
    step(1);
    chk("R3 clear pulse", ptr_clear, 1);
    order_sel = ord_after;
    step(1);
    chk("R3 clear single", ptr_clear, 0);
    chk("R4 byte order", big_endian, ord_rst);
    chk("R4 timing mode", fall_through, !ord_after);
  endtask

  task automatic test_presets();
    full_reset(1'b1, 2'b11, 1'b1, 1'b0);
    chk("R5 preset mode", prog_mode, 1);
    chk("R6 preset64 ae", ofs_ae, 64);
    chk("R6 preset64 af", ofs_af, 64);
    chk("R6 preset ready", ofs_ready, 1);
    full_reset(1'b1, 2'b10, 1'b0, 1'b1);
    chk("R6 preset16 ae", ofs_ae, 16);
    chk("R6 preset16 af", ofs_af, 16);
    full_reset(1'b1, 2'b01, 1'b1, 1'b1);
    chk("R6 preset8 ae", ofs_ae, 8);
    chk("R6 preset8 af", ofs_af, 8);
    // R11: programming strobes ignored in preset mode
    wr_data = 10'd99; prog_wr = 1'b1; ser_en = 1'b1; ser_data = 1'b1;
    step(3);
    prog_wr = 1'b0; ser_en = 1'b0;
    chk("R11 preset ae kept", ofs_ae, 8);
    chk("R11 preset af kept", ofs_af, 8);
  endtask

  task automatic test_glitch();
    int seen_clr = 0, seen_mbox = 0;
    part_rst_n = 1'b0;
    step(3);
    part_rst_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (ptr_clear) seen_clr++;
      if (mbox_force) seen_mbox++;
      step(1);
    end
    chk("R1 short pulse no clear", seen_clr, 0);
    chk("R1 short pulse no mbox", seen_mbox, 0);
    part_rst_n = 1'b0;
    step(4);
    part_rst_n = 1'b1;
    seen_clr = 0;
    for (int i = 0; i < 8; i++) begin
      if (ptr_clear) seen_clr++;
      step(1);
    end
    chk("R1 four edges qualify", seen_clr, 1);
  endtask

  task automatic part_reset_keeps(input int ae, input int af, input int md,
                                  input logic be, input logic ft);
    int seen_clr = 0;
    order_sel = !order_sel; spm_sel = !spm_sel; fs_sel = ~fs_sel;
    part_rst_n = 1'b0;
    step(6);
    chk("R2 partial mbox", mbox_force, 1);
    chk("R2 partial flags", flags_init, 1);
    part_rst_n = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (ptr_clear) seen_clr++;
      step(1);
    end
    chk("R3 partial clear once", seen_clr, 1);
    chk("R9 ae kept", ofs_ae, ae);
    chk("R9 af kept", ofs_af, af);
    chk("R9 mode kept", prog_mode, md);
    chk("R9 ready kept", ofs_ready, 1);
    chk("R9 order kept", big_endian, be);
    chk("R9 timing kept", fall_through, ft);
  endtask

  task automatic test_parallel();
    full_reset(1'b1, 2'b00, 1'b0, 1'b0);
    chk("R5 parallel mode", prog_mode, 2);
    chk("R10 ae cleared", ofs_ae, 0);
    chk("R10 af cleared", ofs_af, 0);
    chk("R10 ready low", ofs_ready, 0);
    ser_en = 1'b1; ser_data = 1'b1;
    step(2);
    ser_en = 1'b0;
    chk("R11 serial ignored in parallel", ofs_ae, 0);
    wr_data = 10'd37; prog_wr = 1'b1;
    step(1);
    prog_wr = 1'b0;
    chk("R7 first write ae", ofs_ae, 37);
    chk("R7 not ready after one", ofs_ready, 0);
    step(2);
    wr_data = 10'd900; prog_wr = 1'b1;
    step(1);
    chk("R7 second write af", ofs_af, 900);
    chk("R7 ready", ofs_ready, 1);
    wr_data = 10'd5;
    step(1);
    prog_wr = 1'b0;
    chk("R7 extra write ignored ae", ofs_ae, 37);
    chk("R7 extra write ignored af", ofs_af, 900);
  endtask

  task automatic test_serial();
    logic [2*W-1:0] stream;
    stream = {10'h2A5, 10'h15A};
    full_reset(1'b0, 2'b11, 1'b1, 1'b1);
    chk("R5 serial mode", prog_mode, 3);
    chk("R10 serial ae cleared", ofs_ae, 0);
    wr_data = 10'd7; prog_wr = 1'b1;
    step(1);
    prog_wr = 1'b0;
    chk("R11 parallel ignored in serial", ofs_ae, 0);
    for (int i = 2*W-1; i >= 0; i--) begin
      ser_en = 1'b0; ser_data = !stream[i];
      step(1);
      if (i == 0) chk("R8 not ready before last bit", ofs_ready, 0);
      ser_en = 1'b1; ser_data = stream[i];
      step(1);
    end
    ser_en = 1'b0;
    chk("R8 serial ae", ofs_ae, 10'h2A5);
    chk("R8 serial af", ofs_af, 10'h15A);
    chk("R8 ready", ofs_ready, 1);
    ser_en = 1'b1; ser_data = 1'b0;
    step(4);
    ser_en = 1'b0;
    chk("R8 extra bits ignored ae", ofs_ae, 10'h2A5);
    chk("R8 extra bits ignored af", ofs_af, 10'h15A);
  endtask

  initial begin
    step(2);
    test_presets();
    part_reset_keeps(8, 8, 1, 1'b1, 1'b0);
    test_glitch();
    test_parallel();
    part_reset_keeps(37, 900, 2, 1'b0, 1'b1);
    test_serial();
    part_reset_keeps(10'h2A5, 10'h15A, 3, 1'b1, 1'b0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL all: watchdog actual running expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule